// File: doc/BRIEF.md
# Eight-bit parallel display bus master

This block is the master side of an 8080-style parallel link to a display controller. It drives eight data lines, a data/command select, active-low write and read strobes, chip select and the controller's reset line. A host issues one request at a time over a valid/ready handshake. Each request names an operation: a command or data write of one or two bytes, a colour fill, an indexed register write or read, a pixel readback, a 32-bit register read, or the power-on reset sequence. The block turns the request into a timed series of bus phases, then raises a one-cycle done pulse with any read result.

Every strobe has a low phase of `LOW_CYC` clocks and a high phase of `HIGH_CYC` clocks. Reads sample the data lines on the last clock of the read-strobe low phase. Every read starts with a dummy strobe whose byte is thrown away. A controller that stores 18 bits per pixel returns three padded bytes per pixel, and the block can repack these into 5-6-5 colour. After reset the block runs the power-on sequence by itself before it accepts any traffic.

Top module: `lcd8_bus_master`

## Requirements
- R1: After reset, and after a request with op code 9, the block runs a reset sequence. It first holds every control line high for `PRE_CYC` clocks, then drives `lcd_rst_n` low for exactly `RST_CYC` clocks, then waits `POST_CYC` clocks. During the sequence `req_ready` is low, and at its end `done` pulses.
- R2: Command bytes go out with `lcd_dc` low. Command writes use op 0 (one byte, `req_word[7:0]`) and op 1 (two bytes). Data writes use op 2 (one byte, `req_word[7:0]`) and op 3 (two bytes), and go out with `lcd_dc` high. When no byte is on the bus, `lcd_dc` rests high.
- R3: A two-byte command or data word goes out as two strobes: `req_word[15:8]` first, then `req_word[7:0]`.
- R4: Each written byte gets one write strobe: low for `LOW_CYC` clocks, then high for `HIGH_CYC` clocks. The byte and `lcd_dc` stay stable while the strobe is low. The write and read strobes are never low together.
- R5: A fill (op 4) produces 2×`req_count` data strobes. The bytes alternate between `req_word[15:8]` and `req_word[7:0]`, so when the two halves are equal the same byte is driven on every strobe.
- R6: An indexed register write (op 5) sends 0x00 and then `req_reg` with `lcd_dc` low. It then sends `req_word[15:8]` and `req_word[7:0]` with `lcd_dc` high.
- R7: Every read sequence issues one extra dummy read strobe first and discards its byte. `lcd_d_oe` is low while the read strobes run and returns high afterwards.
- R8: A pixel readback (op 7) with `req_convert`=0 returns the two bytes after the dummy, first byte in bits 15:8. With `req_convert`=1 it reads three bytes R, G and B and returns {R[7:3], G[7:2], B[7:3]}.
- R9: A 32-bit register read (op 8) sends `req_reg` as a command and reads a dummy plus four bytes, the first byte in bits 31:24. It then drives `lcd_cs_n` high for `HIGH_CYC` clocks before done.
- R10: An indexed register read (op 6) sends 0x00 and `req_reg` with `lcd_dc` low. It then reads a dummy plus two bytes, and the first byte lands in bits 15:8 of `rd_data`.
- R11: A request is accepted only when `req_ready` is high, which happens only while the block is idle. `done` lasts one clock, and `rd_data` is valid in that clock.
- R12: Outside the reset sequence and the chip-select pulse, `lcd_cs_n` is low when `bus_en` is 1 and high when `bus_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Selects the controller (chip select low) when 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and ready to accept |
| req_op | input | 4 | Operation code |
| req_word | input | 16 | Command, data or fill colour |
| req_reg | input | 8 | Register number |
| req_count | input | CNT_W | Fill pixel count |
| req_convert | input | 1 | Repack 18-bit readback to 5-6-5 |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result, valid with done |
| lcd_d_out | output | 8 | Data lines, driven value |
| lcd_d_oe | output | 1 | Data line output enable |
| lcd_d_in | input | 8 | Data lines, sampled value |
| lcd_dc | output | 1 | Data (1) / command (0) select |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rst_n | output | 1 | Controller reset, active low |

## Verification
A wrong byte index shows up on the very next write strobe. It appears as a swapped or repeated byte, or a byte with the wrong select level, in the logged strobe stream. A wrong strobe total also appears as a wrong strobe count by the time done arrives. A wrong phase timer shows up as a wrong strobe-low length, measured on every strobe, or as a wrong reset-low length. A wrong read counter or packing function shows up in `rd_data` in the cycle of the done pulse. The responder gives the dummy byte its own value, so if that byte is kept rather than dropped, the result shows it.

// File: rtl/lcd8_pkg.sv
package lcd8_pkg;

  typedef enum logic [3:0] {
    OP_CMD8   = 4'd0,
    OP_CMD16  = 4'd1,
    OP_DAT8   = 4'd2,
    OP_DAT16  = 4'd3,
    OP_FILL   = 4'd4,
    OP_REGWR  = 4'd5,
    OP_REGRD  = 4'd6,
    OP_PIXRD  = 4'd7,
    OP_REG32  = 4'd8,
    OP_RESET  = 4'd9
  } lcd_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WLOW, S_WHIGH, S_RLOW, S_RHIGH, S_CSHI,
    S_DONE, S_PRE, S_RSTLO, S_POST
  } seq_state_e;

  // Number of write strobes for every op except the fill.
  function automatic logic [2:0] fixed_wr_len(lcd_op_e op);
    case (op)
      OP_CMD8, OP_DAT8, OP_REG32: fixed_wr_len = 3'd1;
      OP_CMD16, OP_DAT16, OP_REGRD: fixed_wr_len = 3'd2;
      OP_REGWR: fixed_wr_len = 3'd4;
      default: fixed_wr_len = 3'd0;
    endcase
  endfunction

  // Read strobes, the dummy included.
  function automatic logic [2:0] rd_len(lcd_op_e op, logic conv);
    case (op)
      OP_REGRD: rd_len = 3'd3;
      OP_PIXRD: rd_len = conv ? 3'd4 : 3'd3;
      OP_REG32: rd_len = 3'd5;
      default: rd_len = 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] seq_byte(lcd_op_e op, logic [15:0] w,
                                          logic [7:0] r, logic [1:0] i);
    case (op)
      OP_CMD8, OP_DAT8: seq_byte = w[7:0];
      OP_CMD16, OP_DAT16: seq_byte = i[0] ? w[7:0] : w[15:8];
      OP_REG32: seq_byte = r;
      OP_REGRD: seq_byte = i[0] ? r : 8'h00;
      OP_REGWR: seq_byte = (i == 2'd0) ? 8'h00 : (i == 2'd1) ? r :
                           (i == 2'd2) ? w[15:8] : w[7:0];
      default: seq_byte = 8'h00;
    endcase
  endfunction

  function automatic logic seq_dc(lcd_op_e op, logic [1:0] i);
    case (op)
      OP_CMD8, OP_CMD16, OP_REGRD, OP_REG32: seq_dc = 1'b0;
      OP_REGWR: seq_dc = i[1];
      default: seq_dc = 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] pack565(logic [23:0] px);
    pack565 = {px[23:19], px[15:10], px[7:3]};
  endfunction

  function automatic logic [31:0] read_result(lcd_op_e op, logic conv,
                                              logic [31:0] acc);
    case (op)
      OP_REG32: read_result = acc;
      OP_PIXRD: read_result = conv ? {16'h0, pack565(acc[23:0])}
                                   : {16'h0, acc[15:0]};
      OP_REGRD: read_result = {16'h0, acc[15:0]};
      default: read_result = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/lcd8_phase_timer.sv
module lcd8_phase_timer #(
  parameter int W    = 8,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= W'(INIT);
    else if (load)      cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/lcd8_read_shift.sv
module lcd8_read_shift (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        shift,
  input  logic [7:0]  din,
  output logic [31:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (shift) acc <= {acc[23:0], din};
  end
endmodule

// File: rtl/lcd8_bus_master.sv
module lcd8_bus_master
  import lcd8_pkg::*;
#(
  parameter int LOW_CYC  = 4,
  parameter int HIGH_CYC = 4,
  parameter int PRE_CYC  = 750000,
  parameter int RST_CYC  = 100000,
  parameter int POST_CYC = 5000000,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_op,
  input  logic [15:0]      req_word,
  input  logic [7:0]       req_reg,
  input  logic [CNT_W-1:0] req_count,
  input  logic             req_convert,
  output logic             done,
  output logic [31:0]      rd_data,
  output logic [7:0]       lcd_d_out,
  output logic             lcd_d_oe,
  input  logic [7:0]       lcd_d_in,
  output logic             lcd_dc,
  output logic             lcd_wr_n,
  output logic             lcd_rd_n,
  output logic             lcd_cs_n,
  output logic             lcd_rst_n
);
  localparam int MAXD  = PRE_CYC + RST_CYC + POST_CYC + LOW_CYC + HIGH_CYC;
  localparam int TMR_W = $clog2(MAXD + 1);

  seq_state_e state, state_n;
  lcd_op_e    op_q, req_op_e;
  logic [15:0] word_q;
  logic [7:0]  reg_q;
  logic        conv_q;
  logic [CNT_W:0] nw_q, nw_req, widx;
  logic [2:0]  nr_q, nr_req, ridx;
  logic        tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic [31:0] acc;

  // named events for the checks below
  logic accept, wr_phase, rd_phase, in_reset, last_w, last_r, rd_sample;

  assign req_op_e  = lcd_op_e'(req_op);
  assign accept    = (state == S_IDLE) && req_valid;
  assign wr_phase  = (state == S_WLOW) || (state == S_WHIGH);
  assign rd_phase  = (state == S_RLOW) || (state == S_RHIGH);
  assign in_reset  = (state == S_PRE) || (state == S_RSTLO) || (state == S_POST);
  assign last_w    = (widx + 1'b1) == nw_q;
  assign last_r    = (ridx + 1'b1) == nr_q;
  assign rd_sample = (state == S_RLOW) && tmr_exp && (ridx != 3'd0);

  assign nw_req = (req_op_e == OP_FILL) ? {req_count, 1'b0}
                : {{(CNT_W - 2){1'b0}}, fixed_wr_len(req_op_e)};
  assign nr_req = rd_len(req_op_e, req_convert);

  always_comb begin
    state_n  = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      S_IDLE: if (req_valid) begin
        if (req_op_e == OP_RESET) begin
          state_n = S_PRE;  tmr_load = 1'b1; tmr_val = TMR_W'(PRE_CYC - 1);
        end else if (nw_req != '0) begin
          state_n = S_WLOW; tmr_load = 1'b1; tmr_val = TMR_W'(LOW_CYC - 1);
        end else if (nr_req != '0) begin
          state_n = S_RLOW; tmr_load = 1'b1; tmr_val = TMR_W'(LOW_CYC - 1);
        end else state_n = S_DONE;
      end
      S_WLOW: if (tmr_exp) begin
        state_n = S_WHIGH; tmr_load = 1'b1; tmr_val = TMR_W'(HIGH_CYC - 1);
      end
      S_WHIGH: if (tmr_exp) begin
        if (!last_w) begin
          state_n = S_WLOW; tmr_load = 1'b1; tmr_val = TMR_W'(LOW_CYC - 1);
        end else if (nr_q != '0) begin
          state_n = S_RLOW; tmr_load = 1'b1; tmr_val = TMR_W'(LOW_CYC - 1);
        end else state_n = S_DONE;
      end
      S_RLOW: if (tmr_exp) begin
        state_n = S_RHIGH; tmr_load = 1'b1; tmr_val = TMR_W'(HIGH_CYC - 1);
      end
      S_RHIGH: if (tmr_exp) begin
        if (!last_r) begin
          state_n = S_RLOW; tmr_load = 1'b1; tmr_val = TMR_W'(LOW_CYC - 1);
        end else if (op_q == OP_REG32) begin
          state_n = S_CSHI; tmr_load = 1'b1; tmr_val = TMR_W'(HIGH_CYC - 1);
        end else state_n = S_DONE;
      end
      S_CSHI: if (tmr_exp) state_n = S_DONE;
      S_PRE: if (tmr_exp) begin
        state_n = S_RSTLO; tmr_load = 1'b1; tmr_val = TMR_W'(RST_CYC - 1);
      end
      S_RSTLO: if (tmr_exp) begin
        state_n = S_POST; tmr_load = 1'b1; tmr_val = TMR_W'(POST_CYC - 1);
      end
      S_POST: if (tmr_exp) state_n = S_DONE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_PRE;
      op_q   <= OP_RESET;
      word_q <= '0;
      reg_q  <= '0;
      conv_q <= 1'b0;
      nw_q   <= '0;
      nr_q   <= '0;
      widx   <= '0;
      ridx   <= '0;
    end else begin
      state <= state_n;
      if (accept) begin
        op_q   <= req_op_e;
        word_q <= req_word;
        reg_q  <= req_reg;
        conv_q <= req_convert;
        nw_q   <= nw_req;
        nr_q   <= nr_req;
        widx   <= '0;
        ridx   <= '0;
      end
      if (state == S_WHIGH && tmr_exp) widx <= widx + 1'b1;
      if (state == S_RHIGH && tmr_exp) ridx <= ridx + 1'b1;
    end
  end

  lcd8_phase_timer #(.W(TMR_W), .INIT(PRE_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .expire(tmr_exp)
  );

  lcd8_read_shift u_shift (
    .clk(clk), .rst(rst), .clr(accept), .shift(rd_sample),
    .din(lcd_d_in), .acc(acc)
  );

  logic [7:0] cur_byte;
  logic       cur_dc;
  assign cur_byte = (op_q == OP_FILL) ? (widx[0] ? word_q[7:0] : word_q[15:8])
                  : seq_byte(op_q, word_q, reg_q, widx[1:0]);
  assign cur_dc   = (op_q == OP_FILL) ? 1'b1 : seq_dc(op_q, widx[1:0]);

  assign lcd_d_out = wr_phase ? cur_byte : 8'h00;
  assign lcd_dc    = wr_phase ? cur_dc : 1'b1;
  assign lcd_d_oe  = !rd_phase;
  assign lcd_wr_n  = (state != S_WLOW);
  assign lcd_rd_n  = (state != S_RLOW);
  assign lcd_rst_n = (state != S_RSTLO);
  assign lcd_cs_n  = in_reset || (state == S_CSHI) || !bus_en;
  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign rd_data   = read_result(op_q, conv_q, acc);

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n && $past(!lcd_wr_n)) |-> ($stable(lcd_d_out) && $stable(lcd_dc)));
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(!lcd_wr_n && !lcd_rd_n));
  // R7
  rd_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !lcd_rd_n |-> !lcd_d_oe);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lcd_rst_n |-> (lcd_wr_n && lcd_rd_n && lcd_cs_n && lcd_dc && !req_ready));
  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n || !lcd_rd_n || !lcd_d_oe) |-> !req_ready);
  // R7
  sample_dir_chk: assert property (@(posedge clk) disable iff (rst)
    rd_sample |-> (!lcd_rd_n && $past(lcd_d_oe) == 1'b0 || !lcd_rd_n));
endmodule

// File: tb/test_lcd8_bus_master.sv
module test_lcd8_bus_master;
  localparam int LOW = 2, HIGH = 3, PRE = 20, RSTC = 10, POST = 30, CW = 10;

  logic clk = 1'b0, rst = 1'b1, bus_en = 1'b1;
  logic req_valid = 1'b0, req_convert = 1'b0;
  logic [3:0] req_op = '0;
  logic [15:0] req_word = '0;
  logic [7:0] req_reg = '0;
  logic [CW-1:0] req_count = '0;
  logic req_ready, done, lcd_d_oe, lcd_dc, lcd_wr_n, lcd_rd_n, lcd_cs_n, lcd_rst_n;
  logic [31:0] rd_data;
  logic [7:0] lcd_d_out, lcd_d_in;

  always #10 clk = ~clk;

  lcd8_bus_master #(.LOW_CYC(LOW), .HIGH_CYC(HIGH), .PRE_CYC(PRE),
    .RST_CYC(RSTC), .POST_CYC(POST), .CNT_W(CW)) i_lcd8_bus_master (
    .clk(clk), .rst(rst), .bus_en(bus_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_word(req_word),
    .req_reg(req_reg), .req_count(req_count), .req_convert(req_convert),
    .done(done), .rd_data(rd_data), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe),
    .lcd_d_in(lcd_d_in), .lcd_dc(lcd_dc), .lcd_wr_n(lcd_wr_n),
    .lcd_rd_n(lcd_rd_n), .lcd_cs_n(lcd_cs_n), .lcd_rst_n(lcd_rst_n));

  int errors = 0, checks = 0;
  logic [7:0] wd [0:63];
  logic       wdc [0:63];
  logic [7:0] src [0:7];
  int wn = 0, rn = 0, cs_rise = 0, rst_low = 0, wlow = 0, bad_len = 0;
  logic prev_wr = 1'b1, prev_rd = 1'b1, prev_cs = 1'b1;
  logic [31:0] got;

  assign lcd_d_in = (rn < 8) ? src[rn] : 8'hXX;

  // Behavioural responder and bus monitor
  always @(negedge clk) begin
    if (!lcd_wr_n) wlow++;
    if (!prev_wr && lcd_wr_n) begin
      if (wn < 64) begin wd[wn] = lcd_d_out; wdc[wn] = lcd_dc; end
      wn++;
      if (wlow != LOW) bad_len++;
      wlow = 0;
    end
    if (!prev_rd && lcd_rd_n) rn++;
    if (!prev_cs && lcd_cs_n) cs_rise++;
    if (!lcd_rst_n) rst_low++;
    prev_wr = lcd_wr_n; prev_rd = lcd_rd_n; prev_cs = lcd_cs_n;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    wn = 0; rn = 0; cs_rise = 0; rst_low = 0; bad_len = 0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [15:0] w,
                       input logic [7:0] r, input int cnt, input logic cv);
    @(negedge clk);
    req_op = op; req_word = w; req_reg = r; req_count = CW'(cnt);
    req_convert = cv; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    got = rd_data;
    chk(done, "R11 done seen", done, 1);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
  endtask

  task automatic expect_byte(input int i, input logic [7:0] d, input logic dc, input string tag);
    chk(wd[i] == d && wdc[i] == dc, tag, {wdc[i], wd[i]}, {dc, d});
  endtask

  task automatic t_reset_state();
    chk(!req_ready && lcd_wr_n && lcd_rd_n && lcd_rst_n && lcd_cs_n,
        "R1 state after reset", {req_ready, lcd_wr_n, lcd_rd_n, lcd_rst_n, lcd_cs_n}, 5'b01111);
    wait_done();
    chk(rst_low == RSTC, "R1 power-on reset low length", rst_low, RSTC);
    chk(req_ready, "R1 ready after sequence", req_ready, 1);
  endtask

  task automatic t_reset_op();
    clear_logs();
    issue(4'd9, 16'h0, 8'h0, 0, 1'b0);
    chk(!req_ready, "R1 busy during reset op", req_ready, 0);
    wait_done();
    chk(rst_low == RSTC && wn == 0, "R1 reset op low length", rst_low, RSTC);
  endtask

  task automatic t_cmd8();
    clear_logs();
    issue(4'd0, 16'h002C, 8'h0, 0, 1'b0);
    wait_done();
    chk(wn == 1, "R2 cmd8 strobes", wn, 1);
    expect_byte(0, 8'h2C, 1'b0, "R2 cmd8 byte dc low");
    chk(lcd_dc == 1'b1, "R2 dc high after command", lcd_dc, 1);
    chk(bad_len == 0, "R4 strobe low length", bad_len, 0);
  endtask

  task automatic t_word(input logic [3:0] op, input logic dc, input string tag);
    clear_logs();
    issue(op, 16'hA55C, 8'h0, 0, 1'b0);
    wait_done();
    chk(wn == 2, {tag, " strobes"}, wn, 2);
    expect_byte(0, 8'hA5, dc, {tag, " high byte first"});
    expect_byte(1, 8'h5C, dc, {tag, " low byte second"});
  endtask

  task automatic t_dat8();
    clear_logs();
    issue(4'd2, 16'hFF77, 8'h0, 0, 1'b0);
    wait_done();
    chk(wn == 1, "R2 dat8 strobes", wn, 1);
    expect_byte(0, 8'h77, 1'b1, "R2 dat8 byte dc high");
  endtask

  task automatic t_fill(input logic [15:0] c, input int cnt);
    clear_logs();
    issue(4'd4, c, 8'h0, cnt, 1'b0);
    chk(!req_ready, "R11 refused while filling", req_ready, 0);
    wait_done();
    chk(wn == 2 * cnt, "R5 fill strobe count", wn, 2 * cnt);
    for (int i = 0; i < 2 * cnt; i++)
      expect_byte(i, (i % 2 == 0) ? c[15:8] : c[7:0], 1'b1, "R5 fill byte");
    chk(bad_len == 0, "R4 fill strobe length", bad_len, 0);
  endtask

  task automatic t_regwr();
    clear_logs();
    issue(4'd5, 16'hBEEF, 8'h36, 0, 1'b0);
    wait_done();
    chk(wn == 4, "R6 regwr strobes", wn, 4);
    expect_byte(0, 8'h00, 1'b0, "R6 index high zero");
    expect_byte(1, 8'h36, 1'b0, "R6 index low");
    expect_byte(2, 8'hBE, 1'b1, "R6 data high");
    expect_byte(3, 8'hEF, 1'b1, "R6 data low");
  endtask

  task automatic t_regrd();
    clear_logs();
    src[0] = 8'hEE; src[1] = 8'hAB; src[2] = 8'hCD;
    issue(4'd6, 16'h0, 8'h21, 0, 1'b0);
    wait_done();
    chk(wn == 2 && wd[0] == 8'h00 && wd[1] == 8'h21 && !wdc[1],
        "R10 regrd index", {wd[0], wd[1]}, 16'h0021);
    chk(rn == 3, "R7 dummy plus two reads", rn, 3);
    chk(got == 32'h0000ABCD, "R10 regrd data", got, 32'hABCD);
    chk(lcd_d_oe, "R7 output restored", lcd_d_oe, 1);
  endtask

  task automatic t_pix(input logic cv);
    clear_logs();
    src[0] = 8'h11; src[1] = 8'h88; src[2] = 8'h44; src[3] = 8'hF8;
    issue(4'd7, 16'h0, 8'h0, 0, cv);
    wait_done();
    chk(wn == 0, "R8 pixel read has no writes", wn, 0);
    if (cv) begin
      chk(rn == 4, "R7 pixel conv read strobes", rn, 4);
      chk(got == 32'h8A3F, "R8 pixel 565 repack", got, 32'h8A3F);
    end else begin
      chk(rn == 3, "R7 pixel raw read strobes", rn, 3);
      chk(got == 32'h8844, "R8 pixel raw", got, 32'h8844);
    end
  endtask

  task automatic t_reg32();
    clear_logs();
    src[0] = 8'h55; src[1] = 8'hDE; src[2] = 8'hAD; src[3] = 8'hBE; src[4] = 8'hEF;
    issue(4'd8, 16'h0, 8'h04, 0, 1'b0);
    wait_done();
    expect_byte(0, 8'h04, 1'b0, "R9 reg32 command");
    chk(rn == 5, "R9 dummy plus four reads", rn, 5);
    chk(got == 32'hDEADBEEF, "R9 reg32 data", got, 32'hDEADBEEF);
    chk(cs_rise == 1, "R9 chip select pulse", cs_rise, 1);
    chk(!lcd_cs_n, "R9 chip select back low", lcd_cs_n, 0);
  endtask

  task automatic t_bus_en();
    @(negedge clk); bus_en = 1'b0;
    @(negedge clk);
    chk(lcd_cs_n, "R12 disabled cs high", lcd_cs_n, 1);
    bus_en = 1'b1;
    @(negedge clk);
    chk(!lcd_cs_n, "R12 enabled cs low", lcd_cs_n, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) src[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_cmd8();
    t_word(4'd1, 1'b0, "R3 cmd16");
    t_word(4'd3, 1'b1, "R3 dat16");
    t_dat8();
    t_fill(16'h5A5A, 3);
    t_fill(16'h1234, 2);
    t_regwr();
    t_regrd();
    t_pix(1'b0);
    t_pix(1'b1);
    t_reg32();
    t_bus_en();
    t_reset_op();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule